// File: doc/BRIEF.md
# Pseudo-Random Piece Selector

This block hands a falling-block game controller a piece index in the range 0 to 6 each time a new piece is needed. Inside, a 7-bit linear feedback shift register steps on every clock edge through a maximal-length cycle of 127 non-zero states. Its low three bits are folded into seven legal piece values. The controller raises a one-cycle spawn request, and the folded value present at that edge is captured into an output register. That register holds its value until the next request.

The register sequence is seeded at reset from a seed counter that never stops and is never cleared, so the starting point depends on how long reset was held. A zero counter value would freeze the register at all zeros. For that case a fixed non-zero seed is loaded instead. The live register state is also brought out, so the controller can inspect it.

Top module: `piece_picker_top`

## Requirements
- R1: After a clock edge with `rst_n` low, `piece_id` reads 0 and `piece_valid` reads 0.
- R2: Each clock edge with `rst_n` high moves `rng_state` one place toward the MSB. The new bit 0 is the XOR of the old bits 6 and 5, which is the polynomial x^7 + x^6 + 1.
- R3: While `rst_n` stays high, `rng_state` returns to any given value after exactly 127 edges and not earlier.
- R4: At a clock edge with `rst_n` low, `rng_state` is loaded with the seed counter's current value. The seed counter starts at 0 at power-up, adds 1 on every edge (reset included) and wraps modulo 128.
- R5: When the seed counter reads 0 at a reset edge, `rng_state` is loaded with 7'b1001101. `rng_state` is never zero once a reset edge has occurred.
- R6: `piece_id` never exceeds 6.
- R7: At an edge where `spawn_req` is high and `rst_n` is high, `piece_id` takes the value of `rng_state[2:0]` from before that edge, with 7 replaced by 0. `piece_valid` goes to 1.
- R8: At an edge where `spawn_req` is low, `piece_id` keeps its value.
- R9: At an edge where `spawn_req` and reset are both asserted, reset takes priority: `piece_id` is 0 and `piece_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; seeds the register |
| spawn_req | input | 1 | One-cycle request to capture a new piece index |
| piece_id | output | 3 | Captured piece index, 0 to 6 |
| piece_valid | output | 1 | High once a piece has been captured since reset |
| rng_state | output | 7 | Current shift register state |

## Verification
Two functions can act on the same edge: the register step and the spawn capture. The bench raises `spawn_req` on consecutive cycles across one full period. Each captured index is compared against the fold of the state seen before that edge, not the state after it. Reset and spawn are also made to coincide: the bench asserts both together and expects reset to win. It then checks that the seed load still comes from the counter value at that edge.

// File: rtl/piece_picker_pkg.sv
// Package: shared widths, constants and helpers for the piece selector.
// Assumes a 7-bit register with feedback taps at bits 6 and 5.
package piece_picker_pkg;

    localparam int unsigned STATE_W    = 7;
    localparam int unsigned PIECE_W    = 3;
    localparam int unsigned NUM_PIECES = 7;
    localparam int unsigned TAP_HI     = STATE_W - 1;
    localparam int unsigned TAP_LO     = STATE_W - 2;
    localparam logic [STATE_W-1:0] SEED_FALLBACK = 7'b1001101;

    typedef logic [STATE_W-1:0] rng_t;
    typedef logic [PIECE_W-1:0] piece_t;

    // Fold a raw code onto the legal piece range by removing one range width.
    function automatic piece_t fold_code(input piece_t raw);
        if (raw >= piece_t'(NUM_PIECES)) begin
            return raw - piece_t'(NUM_PIECES);
        end
        return raw;
    endfunction

endpackage

// File: rtl/seed_counter.sv
// Seed counter: free-running up-counter that is never cleared by reset.
// Assumes a power-up value of zero; it wraps naturally at its width.
module seed_counter
    import piece_picker_pkg::*;
#(
    parameter int unsigned W = STATE_W
) (
    input  logic         clk,
    output logic [W-1:0] count
);

    logic [W-1:0] count_q = '0;

    // Advance on every edge, regardless of reset.
    always_ff @(posedge clk) begin
        count_q <= count_q + W'(1);
    end

    assign count = count_q;

endmodule

// File: rtl/lfsr_core.sv
// Fibonacci shift register: steps left every edge, loads a seed on reset.
// Assumes the caller guarantees a non-zero seed (see zero guard in top).
module lfsr_core
    import piece_picker_pkg::*;
#(
    parameter int unsigned W  = STATE_W,
    parameter int unsigned HI = TAP_HI,
    parameter int unsigned LO = TAP_LO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);

    logic [W-1:0] state_q;
    logic [W-1:0] next_state;

    // Feedback bit enters at the LSB.
    assign next_state[0] = state_q[HI] ^ state_q[LO];

    // Each higher bit takes its lower neighbour.
    for (genvar b = 1; b < W; b++) begin : g_shift
        assign next_state[b] = state_q[b-1];
    end

    // Seed during reset, otherwise step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= seed;
        end else begin
            state_q <= next_state;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/piece_latch.sv
// Piece capture register: folds low state bits into range and holds them
// from one spawn request to the next. Reset wins over a coincident request.
module piece_latch
    import piece_picker_pkg::*;
#(
    parameter int unsigned PW = PIECE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [PW-1:0] raw_code,
    output logic [PW-1:0] piece,
    output logic          valid
);

    logic [PW-1:0] folded;
    logic [PW-1:0] piece_q;
    logic          valid_q;

    // Map the raw code onto 0..NUM_PIECES-1.
    always_comb begin
        folded = fold_code(raw_code);
    end

    // Capture on request, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            piece_q <= '0;
            valid_q <= 1'b0;
        end else if (capture) begin
            piece_q <= folded;
            valid_q <= 1'b1;
        end
    end

    assign piece = piece_q;
    assign valid = valid_q;

endmodule

// File: rtl/piece_picker_top.sv
// Top of the piece selector: seed counter, zero-seed guard, shift register
// and capture register. Assumes spawn_req is synchronous to clk.
module piece_picker_top
    import piece_picker_pkg::*;
#(
    parameter int unsigned SW = STATE_W,
    parameter int unsigned PW = PIECE_W,
    parameter logic [SW-1:0] FALLBACK = SEED_FALLBACK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spawn_req,
    output logic [PW-1:0] piece_id,
    output logic          piece_valid,
    output logic [SW-1:0] rng_state
);

    logic [SW-1:0] cnt;
    logic [SW-1:0] seed;
    logic [SW-1:0] state;

    seed_counter #(.W(SW)) u_cnt (
        .clk   (clk),
        .count (cnt)
    );

    // Zero guard: substitute the fixed seed when the counter reads zero.
    always_comb begin
        seed = (cnt == '0) ? FALLBACK : cnt;
    end

    lfsr_core #(.W(SW), .HI(SW-1), .LO(SW-2)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed),
        .state (state)
    );

    piece_latch #(.PW(PW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (spawn_req),
        .raw_code (state[PW-1:0]),
        .piece    (piece_id),
        .valid    (piece_valid)
    );

    assign rng_state = state;

endmodule

// File: rtl/piece_picker_checker.sv
// Checker for the piece selector, bound onto the top module.
module piece_picker_checker
    import piece_picker_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               spawn_req,
    input logic [PIECE_W-1:0] piece_id,
    input logic               piece_valid,
    input logic [STATE_W-1:0] rng_state
);

    logic seen_rst = 1'b0;
    logic primed   = 1'b0;

    // Track that a reset edge and one further edge have occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        primed <= seen_rst;
    end

    assert_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst |-> rng_state != '0);

    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(rst_n)) |-> rng_state[STATE_W-1:1] == $past(rng_state[STATE_W-2:0]));

    assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst |-> piece_id <= PIECE_W'(NUM_PIECES - 1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(rst_n) && !$past(spawn_req)) |-> $stable(piece_id));

    assert_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(rst_n) && $past(spawn_req)) |-> piece_valid);

    assert_reset_R9: assert property (@(posedge clk)
        (primed && !$past(rst_n)) |-> (piece_id == '0 && !piece_valid));

endmodule

bind piece_picker_top piece_picker_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spawn_req   (spawn_req),
    .piece_id    (piece_id),
    .piece_valid (piece_valid),
    .rng_state   (rng_state)
);

// File: tb/tb_piece_picker_top.sv
module tb_piece_picker_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spawn_req = 1'b0;
    logic [2:0] piece_id;
    logic       piece_valid;
    logic [6:0] rng_state;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;   // 125 MHz

    piece_picker_top dut (
        .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req),
        .piece_id(piece_id), .piece_valid(piece_valid), .rng_state(rng_state)
    );

    // Reference values computed from the requirements.
    logic [6:0] m_cnt = 7'd0;
    logic [6:0] m_st  = 7'd0;
    logic [2:0] m_pc  = 3'd0;
    logic       m_v   = 1'b0;

    function automatic logic [2:0] fold(input logic [6:0] s);
        return (s[2:0] == 3'd7) ? 3'd0 : s[2:0];
    endfunction

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        m_cnt <= m_cnt + 7'd1;
        if (!rst_n) begin
            m_st <= (m_cnt == 7'd0) ? 7'b1001101 : m_cnt;
            m_pc <= 3'd0;
            m_v  <= 1'b0;
        end else begin
            m_st <= {m_st[5:0], m_st[6] ^ m_st[5]};
            if (spawn_req) begin
                m_pc <= fold(m_st);
                m_v  <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Zero counter at the first edge: fallback seed, reset outputs.
    task automatic t_fallback_and_reset();
        rst_n = 1'b0;
        @(negedge clk);
        chk(rng_state == 7'b1001101, "R5", rng_state, 7'b1001101);
        chk(piece_id == 3'd0, "R1", piece_id, 0);
        chk(piece_valid == 1'b0, "R1", piece_valid, 0);
        rst_n = 1'b1;
    endtask

    // Known steps from the fallback seed.
    task automatic t_step();
        @(negedge clk);
        chk(rng_state == 7'h1B, "R2", rng_state, 7'h1B);
        @(negedge clk);
        chk(rng_state == 7'h36, "R2", rng_state, 7'h36);
        @(negedge clk);
        chk(rng_state == m_st, "R2", rng_state, m_st);
    endtask

    // Full period with a spawn every cycle: range, fold and period.
    task automatic t_period_and_spawn();
        logic [6:0] s0;
        logic [6:0] prev;
        int early = 0;
        int zeros = 0;
        int bad_pc = 0;
        int bad_rng = 0;
        s0 = rng_state;
        spawn_req = 1'b1;
        for (int i = 1; i <= 127; i++) begin
            prev = rng_state;
            @(negedge clk);
            if (rng_state == 7'd0) zeros++;
            if (i < 127 && rng_state == s0) early++;
            if (piece_id != fold(prev)) bad_pc++;
            if (piece_id > 3'd6) bad_rng++;
        end
        spawn_req = 1'b0;
        chk(rng_state == s0, "R3", rng_state, s0);
        chk(early == 0, "R3", early, 0);
        chk(zeros == 0, "R5", zeros, 0);
        chk(bad_pc == 0, "R7", bad_pc, 0);
        chk(bad_rng == 0, "R6", bad_rng, 0);
        chk(piece_valid == 1'b1, "R7", piece_valid, 1);
    endtask

    // No request: piece holds while state moves.
    task automatic t_hold();
        logic [2:0] held;
        int moved = 0;
        @(negedge clk);
        spawn_req = 1'b1;
        @(negedge clk);
        spawn_req = 1'b0;
        held = piece_id;
        chk(piece_id == m_pc, "R7", piece_id, m_pc);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (piece_id != held) moved++;
        end
        chk(moved == 0, "R8", moved, 0);
    endtask

    // Reset and spawn together; reset wins, seed from counter.
    task automatic t_reset_spawn();
        logic [6:0] exp_seed;
        exp_seed = (m_cnt == 7'd0) ? 7'b1001101 : m_cnt;
        rst_n = 1'b0;
        spawn_req = 1'b1;
        @(negedge clk);
        chk(piece_id == 3'd0, "R9", piece_id, 0);
        chk(piece_valid == 1'b0, "R9", piece_valid, 0);
        chk(rng_state == exp_seed, "R4", rng_state, exp_seed);
        @(negedge clk);
        chk(piece_valid == 1'b0, "R9", piece_valid, 0);
        spawn_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(rng_state == m_st, "R4", rng_state, m_st);
    endtask

    // Longer reset, different seed; counter keeps running.
    task automatic t_long_reset();
        logic [6:0] exp_seed;
        rst_n = 1'b0;
        for (int i = 0; i < 9; i++) @(negedge clk);
        exp_seed = m_cnt - 7'd1;
        exp_seed = (exp_seed == 7'd0) ? 7'b1001101 : exp_seed;
        chk(rng_state == exp_seed, "R4", rng_state, exp_seed);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rng_state == {exp_seed[5:0], exp_seed[6] ^ exp_seed[5]}, "R2", rng_state, m_st);
    endtask

    // Reset landing on a counter wrap to zero uses the fallback.
    task automatic t_wrap_fallback();
        while (m_cnt != 7'd127) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rng_state == 7'b1001101, "R5", rng_state, 7'b1001101);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 5000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
        finish_run();
    end

    initial begin
        t_fallback_and_reset();
        t_step();
        t_period_and_spawn();
        t_hold();
        t_reset_spawn();
        t_long_reset();
        t_wrap_fallback();
        t_period_and_spawn();
        finish_run();
    end

endmodule